// File: doc/BRIEF.md
# VirtIO PCI Capability Register File

This block serves the VirtIO vendor-specific capability chain inside the configuration space of one PCI function. A configuration agent reads and writes it through a dword-addressed port. The block answers with the header, BAR number, BAR offset and length words of five structures: common configuration, notifications, ISR status, an optional device-specific structure, and the PCI configuration access window. Their next-pointer fields link them into a chain that ends with a zero pointer.

The values for each structure's BAR number, offset and length are fixed at elaboration through parameters. The only state that software can change is the four registers of the configuration access window. These registers are sticky. Only the power-on reset clears them. A function-level reset or a hot/warm reset leaves them as they are and only clears the read pipeline.

Top module: `virtio_cap_regfile`

## Requirements
- R1: The header dwords at dword addresses 0x12, 0x16, 0x2F, 0x33 and 0x37 read as {config type, cap length, next pointer, ID}. Config type is in bits 31:24, cap length in 23:16, next pointer in 15:8 and the ID 0x09 in 7:0. Config types are 1 (0x12), 2 (0x16), 3 (0x2F), 4 (0x33) and 5 (0x37). Cap lengths are 0x14 at 0x16 and 0x37, and 0x10 at the other three.
- R2: The next pointers form a chain: 0x12 points to 0x58, 0x16 to 0xBC, 0x33 to 0xDC and 0x37 to 0x00. The ISR header 0x2F points to 0xCC when DEV_EN=1 and to 0xDC when DEV_EN=0.
- R3: The three dwords after each read-only header hold the BAR number (bits 7:0, bits 31:8 zero), the BAR offset and the structure length, all from parameters. Dword 0x1A holds the notify-offset multiplier.
- R4: With DEV_EN=0, dwords 0x33 to 0x36 read zero.
- R5: Dwords 0x38 to 0x3B are read/write. A write updates only the byte lanes whose bit is set in be_i (bit n covers data bits 8n+7:8n). At 0x38 only bits 7:0 are stored, and bits 31:8 always read zero.
- R6: After the power-on reset rst_ni, the four writable dwords read zero. Their contents survive pulses on flr_i and hot_rst_i.
- R7: Writes to any address other than 0x38 to 0x3B have no effect. Reads of addresses outside the VirtIO ranges return zero.
- R8: A read accepted at a clock edge raises rvalid_o for exactly one cycle after that edge, with rdata_o holding the addressed value. rvalid_o is low after reset.
- R9: In a cycle where flr_i or hot_rst_i is high, reads and writes are dropped (no rvalid_o, no register change), and rvalid_o is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| flr_i | input | 1 | Function-level reset, active high, synchronous |
| hot_rst_i | input | 1 | Hot/warm reset, active high, synchronous |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Dword address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Write byte enables |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |

## Verification
The assertions check on every cycle the one-cycle read latency, the dropping of accesses under function or hot reset, the capability ID in every header, the zero upper bits of BAR indicator words, zero data for unmapped addresses, and that the writable registers stay frozen through non-power resets. The bench's scenarios are the only place that shows the chain can be walked from 0x48 to the end with and without the device-specific structure. They also show that byte-enable merges land in the right lanes, that writes to read-only words leave them unchanged, and that only power-on reset clears the sticky contents.

// File: rtl/virtio_cap_pkg.sv
package virtio_cap_pkg;
  localparam logic [7:0] CAP_ID = 8'h09;

  localparam int unsigned A_CC  = 'h12;
  localparam int unsigned A_NT  = 'h16;
  localparam int unsigned A_IS  = 'h2F;
  localparam int unsigned A_DS  = 'h33;
  localparam int unsigned A_AC  = 'h37;
  localparam int unsigned A_ACR = 'h38;

  function automatic logic [31:0] cap_hdr(input logic [7:0] ctype, input logic [7:0] clen,
                                          input logic [7:0] nxt);
    return {ctype, clen, nxt, CAP_ID};
  endfunction

  function automatic bit is_hdr(input int unsigned a, input bit dev_en);
    return a == A_CC || a == A_NT || a == A_IS || a == A_AC || (dev_en && a == A_DS);
  endfunction

  function automatic bit is_bar_word(input int unsigned a, input bit dev_en);
    return a == A_CC + 1 || a == A_NT + 1 || a == A_IS + 1 || a == A_ACR ||
           (dev_en && a == A_DS + 1);
  endfunction

  function automatic bit is_mapped(input int unsigned a, input bit dev_en);
    return (a >= A_CC && a <= A_NT + 4) || (a >= A_IS && a <= A_IS + 3) ||
           (dev_en && a >= A_DS && a <= A_DS + 3) || (a >= A_AC && a <= A_ACR + 3);
  endfunction
endpackage

// File: rtl/virtio_cap_struct.sv
module virtio_cap_struct
  import virtio_cap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned BASE_ADDR  = 0,
  parameter int unsigned CFG_TYPE   = 1,
  parameter int unsigned CAP_LEN    = 'h10,
  parameter int unsigned NEXT_PTR   = 0,
  parameter int unsigned BAR_NUM    = 0,
  parameter logic [31:0] BAR_OFF    = '0,
  parameter logic [31:0] STRUCT_LEN = '0,
  parameter bit          HAS_MULT   = 1'b0,
  parameter logic [31:0] MULT       = '0,
  parameter bit          PRESENT    = 1'b1,
  parameter bit          HDR_ONLY   = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [31:0]       data_o
);
  localparam int unsigned       NW   = HDR_ONLY ? 1 : (HAS_MULT ? 5 : 4);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] idx;
  assign idx = addr_i - BASE;  // wraps high when addr_i < BASE

  always_comb begin
    hit_o  = PRESENT && (idx < ADDR_W'(NW));
    data_o = '0;
    if (hit_o) begin
      case (idx)
        ADDR_W'(0): data_o = cap_hdr(8'(CFG_TYPE), 8'(CAP_LEN), 8'(NEXT_PTR));
        ADDR_W'(1): data_o = {24'h0, 8'(BAR_NUM)};
        ADDR_W'(2): data_o = BAR_OFF;
        ADDR_W'(3): data_o = STRUCT_LEN;
        ADDR_W'(4): data_o = MULT;
        default:    data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/virtio_sticky_regs.sv
module virtio_sticky_regs #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_ADDR = 'h38,
  parameter int unsigned NREG      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        be_i,
  output logic              hit_o,
  output logic [31:0]       data_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0]    idx;
  logic                 wr_en;
  logic [31:0]          q [NREG];
  logic [NREG*32-1:0]   q_flat;

  assign idx   = addr_i - BASE;
  assign hit_o = idx < ADDR_W'(NREG);
  assign wr_en = wr_i && !blk_i && hit_o;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [3:0] LMASK = (r == 0) ? 4'b0001 : 4'b1111;  // BAR word: byte 0 only
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[r] <= '0;
      end else if (wr_en && idx == ADDR_W'(r)) begin
        for (int b = 0; b < 4; b++)
          if (be_i[b] && LMASK[b]) q[r][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
    assign q_flat[32*r +: 32] = q[r];
  end

  always_comb begin
    data_o = '0;
    for (int r = 0; r < NREG; r++)
      if (hit_o && idx == ADDR_W'(r)) data_o = q[r];
  end

  // R6: function/hot reset cycles never disturb sticky contents
  a_r6_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_i |=> $stable(q_flat));
  // R7: no write strobe, no change
  a_r7_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_flat));
endmodule

// File: rtl/virtio_cap_regfile.sv
module virtio_cap_regfile
  import virtio_cap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter bit          DEV_EN  = 1'b1,
  parameter int unsigned CC_BAR  = 4,
  parameter logic [31:0] CC_OFF  = 32'h0000_0000,
  parameter logic [31:0] CC_LEN  = 32'h0000_0038,
  parameter int unsigned NT_BAR  = 4,
  parameter logic [31:0] NT_OFF  = 32'h0000_1000,
  parameter logic [31:0] NT_LEN  = 32'h0000_1000,
  parameter logic [31:0] NT_MULT = 32'h0000_0004,
  parameter int unsigned IS_BAR  = 4,
  parameter logic [31:0] IS_OFF  = 32'h0000_2000,
  parameter logic [31:0] IS_LEN  = 32'h0000_0004,
  parameter int unsigned DS_BAR  = 4,
  parameter logic [31:0] DS_OFF  = 32'h0000_3000,
  parameter logic [31:0] DS_LEN  = 32'h0000_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flr_i,
  input  logic              hot_rst_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        be_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned NSRC    = 6;
  localparam int unsigned IS_NEXT = DEV_EN ? 'hCC : 'hDC;

  logic              blk;
  logic [NSRC-1:0]   hit;
  logic [31:0]       sdata [NSRC];
  logic [31:0]       rd_mux;

  assign blk = flr_i | hot_rst_i;

  virtio_cap_struct #(.ADDR_W(ADDR_W), .BASE_ADDR(A_CC), .CFG_TYPE(1), .CAP_LEN('h10),
    .NEXT_PTR('h58), .BAR_NUM(CC_BAR), .BAR_OFF(CC_OFF), .STRUCT_LEN(CC_LEN))
    u_cc (.addr_i(addr_i), .hit_o(hit[0]), .data_o(sdata[0]));

  virtio_cap_struct #(.ADDR_W(ADDR_W), .BASE_ADDR(A_NT), .CFG_TYPE(2), .CAP_LEN('h14),
    .NEXT_PTR('hBC), .BAR_NUM(NT_BAR), .BAR_OFF(NT_OFF), .STRUCT_LEN(NT_LEN),
    .HAS_MULT(1'b1), .MULT(NT_MULT))
    u_nt (.addr_i(addr_i), .hit_o(hit[1]), .data_o(sdata[1]));

  virtio_cap_struct #(.ADDR_W(ADDR_W), .BASE_ADDR(A_IS), .CFG_TYPE(3), .CAP_LEN('h10),
    .NEXT_PTR(IS_NEXT), .BAR_NUM(IS_BAR), .BAR_OFF(IS_OFF), .STRUCT_LEN(IS_LEN))
    u_is (.addr_i(addr_i), .hit_o(hit[2]), .data_o(sdata[2]));

  virtio_cap_struct #(.ADDR_W(ADDR_W), .BASE_ADDR(A_DS), .CFG_TYPE(4), .CAP_LEN('h10),
    .NEXT_PTR('hDC), .BAR_NUM(DS_BAR), .BAR_OFF(DS_OFF), .STRUCT_LEN(DS_LEN),
    .PRESENT(DEV_EN))
    u_ds (.addr_i(addr_i), .hit_o(hit[3]), .data_o(sdata[3]));

  virtio_cap_struct #(.ADDR_W(ADDR_W), .BASE_ADDR(A_AC), .CFG_TYPE(5), .CAP_LEN('h14),
    .NEXT_PTR(0), .HDR_ONLY(1'b1))
    u_ac (.addr_i(addr_i), .hit_o(hit[4]), .data_o(sdata[4]));

  virtio_sticky_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(A_ACR), .NREG(4)) u_sticky (
    .clk_i, .rst_ni, .blk_i(blk), .wr_i, .addr_i, .wdata_i, .be_i,
    .hit_o(hit[5]), .data_o(sdata[5]));

  // sources return zero when not hit, so an OR is the mux
  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NSRC; s++) rd_mux |= sdata[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i && !blk;
      if (rd_i && !blk) rdata_o <= rd_mux;
    end
  end

  a_r8_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !blk) |=> rvalid_o);
  a_r9_reset_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk || !rd_i) |=> !rvalid_o);
  a_r1_cap_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && is_hdr(32'($past(addr_i)), DEV_EN)) |-> rdata_o[7:0] == CAP_ID);
  a_r3_bar_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && is_bar_word(32'($past(addr_i)), DEV_EN)) |-> rdata_o[31:8] == 24'h0);
  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !is_mapped(32'($past(addr_i)), DEV_EN)) |-> rdata_o == '0);
  always_comb a_r5_one_hot_decode: assert ($onehot0(hit));
endmodule

// File: tb/sim_virtio_cap_regfile.sv
`timescale 1ns/1ps
module sim_virtio_cap_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flr = 1'b0, hot = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata0, rdata1;
  logic        rvalid0, rvalid1;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m [4];

  always #4 clk = ~clk;  // 125 MHz

  virtio_cap_regfile u0 (.clk_i(clk), .rst_ni(rst_n), .flr_i(flr), .hot_rst_i(hot),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .rdata_o(rdata0), .rvalid_o(rvalid0));
  virtio_cap_regfile #(.DEV_EN(1'b0)) u1 (.clk_i(clk), .rst_ni(rst_n), .flr_i(flr),
    .hot_rst_i(hot), .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .rdata_o(rdata1), .rvalid_o(rvalid1));

  function automatic logic [31:0] exp_rd(input int a, input bit dev);
    case (a)
      'h12: return 32'h0110_5809;
      'h13: return 32'h4;
      'h14: return 32'h0;
      'h15: return 32'h38;
      'h16: return 32'h0214_BC09;
      'h17: return 32'h4;
      'h18: return 32'h1000;
      'h19: return 32'h1000;
      'h1A: return 32'h4;
      'h2F: return dev ? 32'h0310_CC09 : 32'h0310_DC09;
      'h30: return 32'h4;
      'h31: return 32'h2000;
      'h32: return 32'h4;
      'h33: return dev ? 32'h0410_DC09 : 32'h0;
      'h34: return dev ? 32'h4 : 32'h0;
      'h35: return dev ? 32'h3000 : 32'h0;
      'h36: return dev ? 32'h100 : 32'h0;
      'h37: return 32'h0514_0009;
      'h38, 'h39, 'h3A, 'h3B: return m[a - 'h38];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int a, input bit dev);
    if (a == 'h2F) return "R2";
    if (!dev && a >= 'h33 && a <= 'h36) return "R4";
    if (a == 'h12 || a == 'h16 || a == 'h33 || a == 'h37) return "R1";
    if ((a >= 'h13 && a <= 'h1A) || (a >= 'h30 && a <= 'h36)) return "R3";
    if (a >= 'h38 && a <= 'h3B) return "R5";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_read(input int a, input string req0 = "", input string req1 = "");
    @(negedge clk); rd = 1'b1; addr = 10'(a);
    @(negedge clk); rd = 1'b0;
    check("R8", {31'h0, rvalid0}, 32'h1);
    check(req0 == "" ? req_of(a, 1'b1) : req0, rdata0, exp_rd(a, 1'b1));
    check(req1 == "" ? req_of(a, 1'b0) : req1, rdata1, exp_rd(a, 1'b0));
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); wr = 1'b1; addr = 10'(a); wdata = d; be = b;
    @(negedge clk); wr = 1'b0;
    if (a >= 'h38 && a <= 'h3B)
      for (int k = 0; k < 4; k++)
        if (b[k] && (a != 'h38 || k == 0)) m[a - 'h38][8*k +: 8] = d[8*k +: 8];
  endtask

  task automatic pulse_rst(input bit is_hot);
    @(negedge clk); if (is_hot) hot = 1'b1; else flr = 1'b1;
    @(negedge clk); hot = 1'b0; flr = 1'b0;
  endtask

  task automatic walk_chain(input bit dev, input int exp_hops);
    int ptr = 'h48;
    int hops = 0;
    while (ptr != 0 && hops < 8) begin
      @(negedge clk); rd = 1'b1; addr = 10'(ptr >> 2);
      @(negedge clk); rd = 1'b0;
      ptr = dev ? int'(rdata0[15:8]) : int'(rdata1[15:8]);
      check("R2", dev ? rdata0[7:0] : rdata1[7:0], 32'h09);
      hops++;
    end
    check("R2", 32'(hops), 32'(exp_hops));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    check("R8", {31'h0, rvalid0}, 32'h0);
    check("R8", rdata0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", {31'h0, rvalid0}, 32'h0);

    // R1 R3 R4: every mapped word on both variants
    for (int a = 'h12; a <= 'h3B; a++) do_read(a);
    // R2: chain walk with and without device-specific structure
    walk_chain(1'b1, 5);
    walk_chain(1'b0, 4);

    // R8: rvalid lasts one cycle only
    do_read('h16);
    @(negedge clk);
    check("R8", {31'h0, rvalid0}, 32'h0);

    // R5: byte enables and BAR-word mask
    do_write('h38, 32'hFFFF_FFFF, 4'hF);
    do_read('h38, "R5", "R5");
    check("R5", rdata0, 32'h0000_00FF);
    do_write('h39, 32'hA1B2_C3D4, 4'b0101);
    do_read('h39, "R5", "R5");
    check("R5", rdata0, 32'h00B2_00D4);
    do_write('h3B, 32'h1234_5678, 4'hF);
    do_write('h3A, 32'hCAFE_0000, 4'b1100);

    // R6: survive flr and hot reset
    pulse_rst(1'b0);
    do_read('h3B, "R6", "R6");
    pulse_rst(1'b1);
    do_read('h39, "R6", "R6");
    do_read('h3A, "R6", "R6");

    // R9: access during a function reset is dropped
    @(negedge clk); flr = 1'b1; rd = 1'b1; wr = 1'b1; addr = 10'h3B; wdata = 32'hDEAD_BEEF; be = 4'hF;
    @(negedge clk); flr = 1'b0; rd = 1'b0; wr = 1'b0;
    check("R9", {31'h0, rvalid0}, 32'h0);
    do_read('h3B, "R9", "R9");
    @(negedge clk); hot = 1'b1; rd = 1'b1; addr = 10'h12;
    @(negedge clk); hot = 1'b0; rd = 1'b0;
    check("R9", {31'h0, rvalid1}, 32'h0);

    // R7: writes to read-only words ignored, unmapped reads zero
    do_write('h12, 32'h0, 4'hF);
    do_write('h1A, 32'hFFFF_FFFF, 4'hF);
    do_write('h34, 32'hFFFF_FFFF, 4'hF);
    do_read('h12, "R7", "R7");
    do_read('h1A, "R7", "R7");
    do_read('h34, "R7", "R7");
    do_read('h3FF, "R7", "R7");
    do_read('h00, "R7", "R7");
    do_read('h3C, "R7", "R7");

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int unsigned sel = $urandom % 10;
      int a = 'h10 + int'($urandom % 'h30);
      if ($urandom % 16 == 0) a = int'($urandom % 1024);
      if (sel < 5) do_read(a);
      else if (sel < 8) do_write(a, $urandom, 4'($urandom));
      else pulse_rst(sel == 9);
    end

    // R6: power-on reset clears sticky words
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) m[k] = '0;
    for (int a = 'h38; a <= 'h3B; a++) do_read(a, "R6", "R6");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule